// File: doc/BRIEF.md
# Counter-Based Clock Stretcher

This block derives a CPU clock from a reference clock running at twice the nominal CPU rate. A loadable up-counter advances on every rising reference edge. Its most significant bit is the CPU clock. Whenever that bit is low, the counter is in its single low state, and the next edge reloads it instead of counting. An all-ones reload gives one reference period high and one low, which is the normal two-period CPU cycle. A smaller reload keeps the clock high for longer, and each extra reference period adds half a CPU cycle.

An active-low select input and a bypass input are sampled only on the reload edge. Select picks the build-time stretch value, so a slow device can claim extra time at the start of a CPU cycle. Bypass overrides select and always forces the normal cycle, which is useful when bringing a board up.

A second output clocks peripheral timers. Its state machine toggles on every reference edge, except that it is held low while the CPU clock is low. During a whole-cycle stretch it therefore keeps the unstretched waveform. During a fractional stretch it loses exactly one reference period.

Two state machines make up the block. The counter has two phases: PH_HIGH, which counts up, and PH_LOW, which reloads. The transition PH_HIGH→PH_LOW happens on the wrap from all ones to zero, and PH_LOW→PH_HIGH happens on every reload. The timer clock has two states. AUX_HI always goes to AUX_LO. AUX_LO goes to AUX_HI unless the counter is entering PH_LOW, in which case it stays in AUX_LO. The reload selector classifies each reload as LD_NORMAL or LD_STRETCH.

Top module: `clk_stretcher`

## Requirements
- R1: While rst_n is low, the counter holds all ones, and both cpu_clk and tmr_clk are 1.
- R2: If sel_n is 1 (or bypass is 1) on every reload edge, cpu_clk alternates on every rising clk2x edge: one period high, one period low.
- R3: sel_n and bypass are sampled only on the edge that ends the low phase of cpu_clk. A change while cpu_clk is high does not alter the current high phase.
- R4: A reload with sel_n=0 and bypass=0 loads STRETCH_LOAD (legal range 4'h8 to 4'hE). cpu_clk then stays high for 16−STRETCH_LOAD periods. For the default 4'hB that is 5 periods, for 4'hE it is 2, and for 4'h8 it is 8. The low phase is always exactly one period.
- R5: For an odd STRETCH_LOAD (a whole-cycle stretch), tmr_clk toggles on every clk2x edge regardless of stretching.
- R6: tmr_clk is 0 whenever cpu_clk is 0. Otherwise it toggles on each edge. For an even STRETCH_LOAD (a half-cycle stretch), this costs tmr_clk one extra low period per stretched cycle.
- R7: bypass=1 at the reload edge loads all ones whatever sel_n is, so the next high phase lasts one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Reference clock at twice the CPU rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low request for a stretched cycle |
| bypass | input | 1 | Forces unstretched cycles |
| cpu_clk | output | 1 | Stretchable CPU clock (counter MSB) |
| tmr_clk | output | 1 | Timer clock that is not stretched for whole-cycle stretches |

## Verification
The bench builds three instances side by side. The first uses STRETCH_LOAD 4'hB, a two-cycle whole stretch, so the unaffected timer clock is exercised. The second uses 4'hE, the shortest half-cycle stretch, and the third uses 4'h8, the longest half-cycle stretch. Together they cover both timer-clock behaviours and both ends of the high-phase length range. All three receive the same select and bypass stimulus, including select changes in the middle of a high phase. This shows that sampling happens only at the reload edge.

// File: rtl/clk_stretcher_pkg.sv
package clk_stretcher_pkg;

    // Phase of the loadable counter, decoded from its MSB
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

    // Kind of reload chosen at the end of the low phase
    typedef enum logic {
        LD_NORMAL  = 1'b0,
        LD_STRETCH = 1'b1
    } load_kind_t;

    // Timer clock state
    typedef enum logic {
        AUX_LO = 1'b0,
        AUX_HI = 1'b1
    } aux_state_t;

endpackage

// File: rtl/stretch_reload_sel.sv
module stretch_reload_sel
    import clk_stretcher_pkg::*;
#(
    parameter int                 CNT_W        = 4,
    parameter logic [CNT_W-1:0]   STRETCH_LOAD = 4'hB
) (
    input  logic             sel_n,
    input  logic             bypass,
    output logic [CNT_W-1:0] load_val
);

    localparam logic [CNT_W-1:0] NORMAL_LOAD = '1;

    load_kind_t kind;

    // Classify the reload; bypass always wins over the select request
    always_comb begin
        if (bypass || sel_n) kind = LD_NORMAL;
        else                 kind = LD_STRETCH;
    end

    always_comb begin
        unique case (kind)
            LD_NORMAL:  load_val = NORMAL_LOAD;
            LD_STRETCH: load_val = STRETCH_LOAD;
            default:    load_val = NORMAL_LOAD;
        endcase
    end

endmodule

// File: rtl/stretch_counter.sv
module stretch_counter
    import clk_stretcher_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_val,
    output logic             msb,
    output logic             low_next
);

    localparam int               MSB   = CNT_W - 1;
    localparam logic [CNT_W-1:0] ONES  = '1;
    localparam logic [CNT_W-1:0] ONE   = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    phase_t           phase;

    always_comb begin
        phase = cnt_q[MSB] ? PH_HIGH : PH_LOW;
    end

    // Next-state: count while high, reload in the single low state
    always_comb begin
        unique case (phase)
            PH_HIGH: cnt_nxt = cnt_q + ONE;
            PH_LOW:  cnt_nxt = load_val;
            default: cnt_nxt = ONES;
        endcase
    end

    // State register
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) cnt_q <= ONES;
        else        cnt_q <= cnt_nxt;
    end

    // Outputs
    always_comb begin
        msb      = cnt_q[MSB];
        low_next = ~cnt_nxt[MSB];
    end

    // R3
    count_while_high_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        cnt_q[MSB] |=> (cnt_q == $past(cnt_q) + ONE));

    // R3
    reload_from_low_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !cnt_q[MSB] |=> (cnt_q == $past(load_val)));

    // R4
    low_single_period_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !cnt_q[MSB] |=> cnt_q[MSB]);

endmodule

// File: rtl/stretch_aux_clk.sv
module stretch_aux_clk
    import clk_stretcher_pkg::*;
(
    input  logic clk2x,
    input  logic rst_n,
    input  logic cpu_msb,
    input  logic low_next,
    output logic tmr_clk
);

    aux_state_t state_q;
    aux_state_t state_nxt;

    // Toggle every edge, but hold low when the counter enters its low state
    always_comb begin
        unique case (state_q)
            AUX_HI:  state_nxt = AUX_LO;
            AUX_LO:  state_nxt = low_next ? AUX_LO : AUX_HI;
            default: state_nxt = AUX_HI;
        endcase
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) state_q <= AUX_HI;
        else        state_q <= state_nxt;
    end

    always_comb begin
        tmr_clk = (state_q == AUX_HI);
    end

    // R6
    tmr_low_with_cpu_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !cpu_msb |-> !tmr_clk);

endmodule

// File: rtl/clk_stretcher.sv
module clk_stretcher
    import clk_stretcher_pkg::*;
#(
    parameter int                 CNT_W        = 4,
    parameter logic [CNT_W-1:0]   STRETCH_LOAD = 4'hB
) (
    input  logic clk2x,
    input  logic rst_n,
    input  logic sel_n,
    input  logic bypass,
    output logic cpu_clk,
    output logic tmr_clk
);

    localparam bit WHOLE_STRETCH = STRETCH_LOAD[0];

    logic [CNT_W-1:0] load_val;
    logic             low_next;

    stretch_reload_sel #(
        .CNT_W        (CNT_W),
        .STRETCH_LOAD (STRETCH_LOAD)
    ) u_sel (
        .sel_n    (sel_n),
        .bypass   (bypass),
        .load_val (load_val)
    );

    stretch_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .load_val (load_val),
        .msb      (cpu_clk),
        .low_next (low_next)
    );

    stretch_aux_clk u_aux (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .cpu_msb  (cpu_clk),
        .low_next (low_next),
        .tmr_clk  (tmr_clk)
    );

    // R7
    bypass_normal_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!cpu_clk && bypass) |=> (cpu_clk ##1 !cpu_clk));

    generate
        if (WHOLE_STRETCH) begin : g_whole
            // R5
            tmr_free_toggle_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
                1'b1 |=> (tmr_clk != $past(tmr_clk)));
        end
    endgenerate

endmodule

// File: tb/tb_clk_stretcher.sv
module tb_clk_stretcher;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       bypass = 1'b0;
    logic [2:0] cpu_v;
    logic [2:0] tmr_v;

    int checks = 0;
    int failures = 0;
    string phase_tag = "R1";

    always #2 clk = ~clk;   // 250 MHz

    clk_stretcher #(.CNT_W(4), .STRETCH_LOAD(4'hB)) dut (
        .clk2x(clk), .rst_n(rst_n), .sel_n(sel_n), .bypass(bypass),
        .cpu_clk(cpu_v[0]), .tmr_clk(tmr_v[0]));
    clk_stretcher #(.CNT_W(4), .STRETCH_LOAD(4'hE)) dut_e (
        .clk2x(clk), .rst_n(rst_n), .sel_n(sel_n), .bypass(bypass),
        .cpu_clk(cpu_v[1]), .tmr_clk(tmr_v[1]));
    clk_stretcher #(.CNT_W(4), .STRETCH_LOAD(4'h8)) dut_8 (
        .clk2x(clk), .rst_n(rst_n), .sel_n(sel_n), .bypass(bypass),
        .cpu_clk(cpu_v[2]), .tmr_clk(tmr_v[2]));

    function automatic int ld(input int i);
        return (i == 0) ? 11 : ((i == 1) ? 14 : 8);
    endfunction

    // Behavioural reference: remaining high periods, clock levels
    int m_left [3];
    bit m_cpu  [3];
    bit m_tmr  [3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_left[i] = 1; m_cpu[i] = 1'b1; m_tmr[i] = 1'b1;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (!m_cpu[i]) begin
                    m_left[i] = 16 - ((bypass || sel_n) ? 15 : ld(i));
                    m_cpu[i]  = 1'b1;
                end else begin
                    m_left[i] = m_left[i] - 1;
                    if (m_left[i] == 0) m_cpu[i] = 1'b0;
                end
                m_tmr[i] = m_cpu[i] ? !m_tmr[i] : 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 3; i++) begin
                check(phase_tag, cpu_v[i], m_cpu[i], $sformatf("cpu_clk inst%0d", i));
                check((i == 0) ? "R5" : "R6", tmr_v[i], m_tmr[i], $sformatf("tmr_clk inst%0d", i));
            end
        end
    end

    // Length of the next high phase of instance idx, in clk2x periods
    task automatic measure_high(input int idx, output int n);
        do @(negedge clk); while (cpu_v[idx] != 1'b0);
        n = 0;
        forever begin
            @(negedge clk);
            if (cpu_v[idx]) n++;
            else break;
        end
    endtask

    initial begin
        int n;
        logic [7:0] lfsr;
        // R1 reset state
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check("R1", cpu_v[i], 1, $sformatf("reset cpu_clk inst%0d", i));
            check("R1", tmr_v[i], 1, $sformatf("reset tmr_clk inst%0d", i));
        end
        rst_n = 1'b1;

        // R2 normal cycles
        phase_tag = "R2";
        repeat (10) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            measure_high(i, n);
            check("R2", n, 1, $sformatf("normal high length inst%0d", i));
        end

        // R4 stretched cycles
        phase_tag = "R4";
        sel_n = 1'b0;
        repeat (12) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            measure_high(i, n);
            check("R4", n, 16 - ld(i), $sformatf("stretched high length inst%0d", i));
        end

        // R3 select released right after a stretched reload has no effect on it
        phase_tag = "R3";
        do @(negedge clk); while (cpu_v[0] != 1'b0);
        @(negedge clk);
        sel_n = 1'b1;
        n = 1;
        forever begin
            @(negedge clk);
            if (cpu_v[0]) n++;
            else break;
        end
        check("R3", n, 5, "high length after mid-phase sel_n release");
        measure_high(0, n);
        check("R3", n, 1, "next high length after release");

        // R7 bypass overrides select
        phase_tag = "R7";
        bypass = 1'b1;
        sel_n  = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            measure_high(i, n);
            check("R7", n, 1, $sformatf("bypass high length inst%0d", i));
        end
        bypass = 1'b0;

        // R3 pseudo-random select and bypass changes every cycle
        phase_tag = "R3";
        lfsr = 8'hA5;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            sel_n  = lfsr[0];
            bypass = (lfsr[3:1] == 3'b111);
        end
        sel_n = 1'b1; bypass = 1'b0;
        repeat (10) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule